// File: doc/BRIEF.md
# Code Store Protection and Verify Unit

This block guards the read-back and programming path of a small on-chip code store. A programmer drives a static operation code on five control pins, an address, and a data byte, then toggles a program strobe. Code bytes, the bytes of a 64-entry scrambling table and three protection bits behave like erasable programmable cells. Programming can only turn ones into zeros. A separate erase input returns every cell to one.

Verify reads do not return the raw code byte. They return the code byte XNORed with the table byte selected by the six low address bits, so an erased table leaves the code readable unchanged. The three protection bits raise a protection level step by step. The first level stops further programming and stops table-read instructions in external code from reading internal bytes. It also freezes the external-access pin at the value sampled after reset. The second level also stops verify, and the third also stops execution from external memory. A fixed identification read returns three constant bytes. A denied request raises a one-cycle rejected flag, and the data returned for it is FFh.

Top module: `epg_top`

## Requirements
- R1: The operation is decoded from `ctl[4:0]`, listed MSB first: 01111 programs a code byte, 01101 programs a table byte, 11111, 11100 and 10110 program protection bits 1, 2 and 3, 00011 is verify and 00000 is the identification read. Any other code is idle. `dout` and `rejected` are registered one cycle after their inputs. At reset and in idle, `dout` reads FFh and `rejected` reads 0.
- R2: Holding `erase` high for one cycle sets every code byte, table byte and protection bit to one. From the next cycle all four permit outputs are 1, and a verify of any address returns FFh.
- R3: A code-byte write takes effect on the CODE_PULSES-th (default 5) rising edge of `prog_strobe`. After one pulse fewer, the byte is still unchanged.
- R4: Programming only clears bits. The stored value becomes the old value ANDed with `din`.
- R5: Verify returns `~(code[addr] ^ table[addr[5:0]])`. With an erased table this is the code byte itself.
- R6: A table-byte write, addressed by `addr[5:0]`, takes effect on the CFG_PULSES-th (default 25) strobe rising edge.
- R7: With protection bit 1 programmed (level 1), `prog_ok` and `tbl_ok` read 0 and code and table writes are ignored. `ea_eff` holds the `ea_pin` value sampled on the first clock after reset, while verify and `ext_ok` stay permitted. When no bit is programmed, `ea_eff` follows `ea_pin`.
- R8: With bits 1 and 2 programmed (level 2), `verify_ok` reads 0 and verify returns FFh.
- R9: With all three bits programmed, `ext_ok` reads 0. Any other combination of programmed bits counts as the most restrictive level.
- R10: A strobe rising edge in a denied programming operation, or a verify request that is new (new mode, address or data) and denied, gives `rejected` high for one cycle with `dout` at FFh.
- R11: The identification read returns 89h at address 30h, 58h at 31h, and FCh at 60h (FBh when SIZE_VARIANT is 0). Every other address returns FFh.
- R12: Any change of `ctl`, `addr` or `din` during a programming operation restarts its pulse count.
- R13: Protection-bit writes need CFG_PULSES strobe edges and are accepted at every protection level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low (stored cells keep their values) |
| ctl | input | 5 | Static operation code |
| prog_strobe | input | 1 | Program strobe; rising edges are counted |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data byte to program |
| erase | input | 1 | Returns all cells to one |
| ea_pin | input | 1 | External-access pin level |
| dout | output | 8 | Registered read-out byte |
| rejected | output | 1 | One-cycle flag for a denied request |
| prog_ok | output | 1 | Programming permitted |
| verify_ok | output | 1 | Verify permitted |
| tbl_ok | output | 1 | Table reads of internal code from external code permitted |
| ext_ok | output | 1 | Execution from external memory permitted |
| ea_eff | output | 1 | Effective external-access level |

## Verification
A table of address, code and table-byte triples is programmed and read back twice. The first read, with the table erased, shows that the code itself is returned. The second read shows that the XNOR uses the right table entry, because each triple has its own six low address bits. Directed sequences stop one strobe pulse short, change the operation in the middle of a count, and write over a byte a second time. These show that the pulse count restarts and that programming can only clear bits. The protection bits are then raised one at a time, and one bit is programmed out of order. These runs separate the four permit levels, the frozen external-access level across a reset, and the rejected pulse with its FFh data.

// File: rtl/epg_pkg.sv
package epg_pkg;

    // Operation codes on ctl[4:0], MSB first
    localparam logic [4:0] CTL_PGM_CODE = 5'b01111;
    localparam logic [4:0] CTL_PGM_TBL  = 5'b01101;
    localparam logic [4:0] CTL_LOCK1    = 5'b11111;
    localparam logic [4:0] CTL_LOCK2    = 5'b11100;
    localparam logic [4:0] CTL_LOCK3    = 5'b10110;
    localparam logic [4:0] CTL_VERIFY   = 5'b00011;
    localparam logic [4:0] CTL_IDENT    = 5'b00000;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PGM_CODE,
        OP_PGM_TBL,
        OP_LOCK1,
        OP_LOCK2,
        OP_LOCK3,
        OP_VERIFY,
        OP_IDENT
    } op_e;

    typedef struct packed {
        logic prog_ok;
        logic verify_ok;
        logic tbl_ok;
        logic ext_ok;
        logic ea_hold;
    } permit_t;

endpackage

// File: rtl/epg_mode_dec.sv
module epg_mode_dec
    import epg_pkg::*;
(
    input  logic [4:0] ctl,
    output op_e        op
);
    always_comb begin
        case (ctl)
            CTL_PGM_CODE: op = OP_PGM_CODE;
            CTL_PGM_TBL:  op = OP_PGM_TBL;
            CTL_LOCK1:    op = OP_LOCK1;
            CTL_LOCK2:    op = OP_LOCK2;
            CTL_LOCK3:    op = OP_LOCK3;
            CTL_VERIFY:   op = OP_VERIFY;
            CTL_IDENT:    op = OP_IDENT;
            default:      op = OP_IDLE;
        endcase
    end
endmodule

// File: rtl/epg_lock_policy.sv
module epg_lock_policy
    import epg_pkg::*;
(
    input  logic [2:0] lock,   // 1 = unprogrammed, bit 0 = first protection bit
    output permit_t    perm
);
    logic [1:0] level;

    always_comb begin
        case (lock)
            3'b111:  level = 2'd0;
            3'b110:  level = 2'd1;
            3'b100:  level = 2'd2;
            default: level = 2'd3;   // full set and every undefined mix
        endcase
        perm.prog_ok   = (level == 2'd0);
        perm.tbl_ok    = (level == 2'd0);
        perm.verify_ok = (level <= 2'd1);
        perm.ext_ok    = (level <= 2'd2);
        perm.ea_hold   = (level != 2'd0);
    end
endmodule

// File: rtl/epg_store.sv
module epg_store #(
    parameter int CODE_DEPTH = 256,
    parameter int TBL_DEPTH  = 64,
    parameter int N_LOCK     = 3,
    localparam int CODE_AW   = $clog2(CODE_DEPTH),
    localparam int TBL_AW    = $clog2(TBL_DEPTH)
) (
    input  logic               clk,
    input  logic               erase,
    input  logic               code_we,
    input  logic [CODE_AW-1:0] code_idx,
    input  logic               tbl_we,
    input  logic [TBL_AW-1:0]  tbl_idx,
    input  logic [N_LOCK-1:0]  lock_we,
    input  logic [7:0]         wdata,
    output logic [7:0]         code_rd,
    output logic [7:0]         tbl_rd,
    output logic [N_LOCK-1:0]  lock
);
    // Cells are non-volatile: no reset, only erase returns them to one
    logic [7:0] code_q [CODE_DEPTH];
    logic [7:0] tbl_q  [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < CODE_DEPTH; i++) code_q[i] <= 8'hFF;
        end else if (code_we) begin
            code_q[code_idx] <= code_q[code_idx] & wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < TBL_DEPTH; i++) tbl_q[i] <= 8'hFF;
        end else if (tbl_we) begin
            tbl_q[tbl_idx] <= tbl_q[tbl_idx] & wdata;
        end
    end

    for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
        logic bit_q;
        always_ff @(posedge clk) begin
            if (erase)          bit_q <= 1'b1;
            else if (lock_we[g]) bit_q <= 1'b0;
        end
        assign lock[g] = bit_q;
    end

    assign code_rd = code_q[code_idx];
    assign tbl_rd  = tbl_q[tbl_idx];
endmodule

// File: rtl/epg_top.sv
module epg_top
    import epg_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int CODE_DEPTH   = 256,
    parameter int CODE_PULSES  = 5,
    parameter int CFG_PULSES   = 25,
    parameter bit SIZE_VARIANT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        ctl,
    input  logic              prog_strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              erase,
    input  logic              ea_pin,
    output logic [7:0]        dout,
    output logic              rejected,
    output logic              prog_ok,
    output logic              verify_ok,
    output logic              tbl_ok,
    output logic              ext_ok,
    output logic              ea_eff
);
    localparam int TBL_DEPTH = 64;
    localparam int TBL_AW    = $clog2(TBL_DEPTH);
    localparam int CODE_AW   = $clog2(CODE_DEPTH);
    localparam int MAX_PULSE = (CODE_PULSES > CFG_PULSES) ? CODE_PULSES : CFG_PULSES;
    localparam int CNT_W     = $clog2(MAX_PULSE + 1);
    localparam logic [CNT_W-1:0] NEED_CODE = CNT_W'(CODE_PULSES);
    localparam logic [CNT_W-1:0] NEED_CFG  = CNT_W'(CFG_PULSES);
    localparam logic [7:0] ID_VARIANT = SIZE_VARIANT ? 8'hFC : 8'hFB;

    typedef struct packed {
        logic              strobe;
        logic [CNT_W-1:0]  cnt;
        logic              kvalid;
        logic [4:0]        kctl;
        logic [ADDR_W-1:0] kaddr;
        logic [7:0]        kdin;
        logic [7:0]        dout;
        logic              rej;
        logic              started;
        logic              ea_lat;
    } state_t;

    state_t st_d, st_q;

    op_e        op;
    permit_t    perm;
    logic [2:0] lock;
    logic [7:0] code_rd, tbl_rd;
    logic       commit;
    logic [2:0] lock_we;

    epg_mode_dec u_dec (.ctl(ctl), .op(op));

    epg_lock_policy u_pol (.lock(lock), .perm(perm));

    epg_store #(.CODE_DEPTH(CODE_DEPTH), .TBL_DEPTH(TBL_DEPTH), .N_LOCK(3)) u_store (
        .clk      (clk),
        .erase    (erase),
        .code_we  (commit && op == OP_PGM_CODE),
        .code_idx (addr[CODE_AW-1:0]),
        .tbl_we   (commit && op == OP_PGM_TBL),
        .tbl_idx  (addr[TBL_AW-1:0]),
        .lock_we  (lock_we),
        .wdata    (din),
        .code_rd  (code_rd),
        .tbl_rd   (tbl_rd),
        .lock     (lock)
    );

    assign lock_we[0] = commit && op == OP_LOCK1;
    assign lock_we[1] = commit && op == OP_LOCK2;
    assign lock_we[2] = commit && op == OP_LOCK3;

    function automatic logic [7:0] ident_byte(input logic [ADDR_W-1:0] a);
        if (a == ADDR_W'('h30))      return 8'h89;
        else if (a == ADDR_W'('h31)) return 8'h58;
        else if (a == ADDR_W'('h60)) return ID_VARIANT;
        else                         return 8'hFF;
    endfunction

    logic             rise, key_new, is_pgm, is_lock, allowed;
    logic [CNT_W-1:0] base, inc, need;

    always_comb begin
        st_d    = st_q;
        commit  = 1'b0;
        rise    = prog_strobe & ~st_q.strobe;
        key_new = !st_q.kvalid || (ctl != st_q.kctl) ||
                  (addr != st_q.kaddr) || (din != st_q.kdin);
        is_lock = (op == OP_LOCK1) || (op == OP_LOCK2) || (op == OP_LOCK3);
        is_pgm  = is_lock || (op == OP_PGM_CODE) || (op == OP_PGM_TBL);
        allowed = is_lock || perm.prog_ok;
        need    = (op == OP_PGM_CODE) ? NEED_CODE : NEED_CFG;
        base    = key_new ? '0 : st_q.cnt;
        inc     = base + 1'b1;

        st_d.strobe  = prog_strobe;
        st_d.kvalid  = 1'b1;
        st_d.kctl    = ctl;
        st_d.kaddr   = addr;
        st_d.kdin    = din;
        st_d.rej     = 1'b0;
        st_d.started = 1'b1;
        if (!st_q.started) st_d.ea_lat = ea_pin;

        // pulse counting and commit
        if (erase || !is_pgm) begin
            st_d.cnt = '0;
        end else if (rise && !allowed) begin
            st_d.cnt = base;
            st_d.rej = 1'b1;
        end else if (rise && inc == need) begin
            st_d.cnt = '0;
            commit   = 1'b1;
        end else if (rise) begin
            st_d.cnt = inc;
        end else begin
            st_d.cnt = base;
        end

        // read-out path
        case (op)
            OP_VERIFY: begin
                if (perm.verify_ok) begin
                    st_d.dout = ~(code_rd ^ tbl_rd);
                end else begin
                    st_d.dout = 8'hFF;
                    if (key_new) st_d.rej = 1'b1;
                end
            end
            OP_IDENT: st_d.dout = ident_byte(addr);
            default:  st_d.dout = 8'hFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.dout <= 8'hFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout      = st_q.dout;
    assign rejected  = st_q.rej;
    assign prog_ok   = perm.prog_ok;
    assign verify_ok = perm.verify_ok;
    assign tbl_ok    = perm.tbl_ok;
    assign ext_ok    = perm.ext_ok;
    assign ea_eff    = perm.ea_hold ? st_q.ea_lat : ea_pin;
endmodule

// File: rtl/epg_checker.sv
module epg_checker
    import epg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] ctl,
    input logic       erase,
    input logic [7:0] dout,
    input logic       rejected,
    input logic       prog_ok,
    input logic       verify_ok,
    input logic       tbl_ok,
    input logic       ext_ok
);
    // R2
    erase_opens_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (prog_ok && verify_ok && tbl_ok && ext_ok));

    // R7
    prog_implies_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |-> (tbl_ok && verify_ok && ext_ok));

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_ok && !erase) |=> !prog_ok);

    // R8
    verify_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_VERIFY && !verify_ok) |=> (dout == 8'hFF));

    // R9
    ext_implies_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ok |-> (!verify_ok && !prog_ok));

    // R10
    reject_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> (dout == 8'hFF));
endmodule

bind epg_top epg_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .erase     (erase),
    .dout      (dout),
    .rejected  (rejected),
    .prog_ok   (prog_ok),
    .verify_ok (verify_ok),
    .tbl_ok    (tbl_ok),
    .ext_ok    (ext_ok)
);

// File: tb/epg_top_tb_top.sv
module epg_top_tb_top;
    import epg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ctl = 5'b01010;
    logic        prog_strobe = 1'b0;
    logic [13:0] addr = '0;
    logic [7:0]  din = '0;
    logic        erase = 1'b0;
    logic        ea_pin = 1'b0;
    logic [7:0]  dout;
    logic        rejected, prog_ok, verify_ok, tbl_ok, ext_ok, ea_eff;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    epg_top dut_i (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .prog_strobe(prog_strobe),
        .addr(addr), .din(din), .erase(erase), .ea_pin(ea_pin),
        .dout(dout), .rejected(rejected), .prog_ok(prog_ok),
        .verify_ok(verify_ok), .tbl_ok(tbl_ok), .ext_ok(ext_ok), .ea_eff(ea_eff)
    );

    // {address, code byte, table byte}; every low-6-bit index differs
    localparam logic [29:0] VEC [6] = '{
        {14'h0005, 8'hA5, 8'h3C},
        {14'h0012, 8'h00, 8'hFF},
        {14'h0027, 8'hFF, 8'h00},
        {14'h0039, 8'h5A, 8'h5A},
        {14'h00C1, 8'h81, 8'h7E},
        {14'h00EE, 8'h3F, 8'hC9}
    };

    logic [13:0] va;
    logic [7:0]  vc, ve;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [4:0] c, input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        ctl = c; addr = a; din = d;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) prog_strobe = 1'b1;
            @(negedge clk) prog_strobe = 1'b0;
        end
    endtask

    task automatic read_at(input logic [4:0] c, input logic [13:0] a);
        setup(c, a, 8'h00);
        @(negedge clk);
    endtask

    task automatic do_erase();
        @(negedge clk) erase = 1'b1;
        @(negedge clk) erase = 1'b0;
    endtask

    function automatic logic [7:0] perms();
        return {4'b0, prog_ok, verify_ok, tbl_ok, ext_ok};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 reset dout", dout, 8'hFF);
        check("R1 reset rejected", {7'b0, rejected}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 erase
        do_erase();
        check("R2 permits after erase", perms(), 8'h0F);
        read_at(CTL_VERIFY, 14'h0005);
        check("R2 erased verify", dout, 8'hFF);

        // R1 idle code reads FF
        read_at(5'b01010, 14'h0005);
        check("R1 idle dout", dout, 8'hFF);

        // Vector table: R3 code write, R5 unscrambled, R6 table write, R5 scrambled
        for (int i = 0; i < 6; i++) begin
            va = VEC[i][29:16]; vc = VEC[i][15:8]; ve = VEC[i][7:0];
            setup(CTL_PGM_CODE, va, vc);
            pulses(5);
            read_at(CTL_VERIFY, va);
            check("R5 plain verify", dout, vc);
            setup(CTL_PGM_TBL, va, ve);
            pulses(25);
            read_at(CTL_VERIFY, va);
            check("R6 scrambled verify", dout, ~(vc ^ ve));
        end
        do_erase();

        // R12 restart / R3 pulse count
        setup(CTL_PGM_CODE, 14'h0010, 8'h5A);
        pulses(4);
        read_at(CTL_VERIFY, 14'h0010);
        check("R3 four pulses no write", dout, 8'hFF);
        setup(CTL_PGM_CODE, 14'h0010, 8'h5A);
        pulses(4);
        read_at(CTL_VERIFY, 14'h0010);
        check("R12 count restarted", dout, 8'hFF);
        setup(CTL_PGM_CODE, 14'h0010, 8'h5A);
        pulses(5);
        read_at(CTL_VERIFY, 14'h0010);
        check("R3 five pulses write", dout, 8'h5A);

        // R4 only clears
        setup(CTL_PGM_CODE, 14'h0010, 8'h0F);
        pulses(5);
        read_at(CTL_VERIFY, 14'h0010);
        check("R4 and-merge", dout, 8'h0A);

        // R11 identification
        read_at(CTL_IDENT, 14'h0030);
        check("R11 id 30h", dout, 8'h89);
        read_at(CTL_IDENT, 14'h0031);
        check("R11 id 31h", dout, 8'h58);
        read_at(CTL_IDENT, 14'h0060);
        check("R11 id 60h", dout, 8'hFC);
        read_at(CTL_IDENT, 14'h0044);
        check("R11 id other", dout, 8'hFF);

        // R9 undefined mix: only bit 2 programmed; R13 lock write
        setup(CTL_LOCK2, 14'h0000, 8'h00);
        pulses(24);
        check("R13 24 pulses no lock", perms(), 8'h0F);
        pulses(1);
        check("R9 undefined mix most restrictive", perms(), 8'h00);
        do_erase();
        check("R2 erase after locks", perms(), 8'h0F);

        // R7 level 1
        ea_pin = 1'b1;
        @(negedge clk);
        check("R7 ea follows pin unlocked", {7'b0, ea_eff}, 8'h01);
        setup(CTL_PGM_CODE, 14'h0020, 8'hC3);
        pulses(5);
        setup(CTL_LOCK1, 14'h0000, 8'h00);
        pulses(25);
        check("R7 level1 permits", perms(), 8'h05);
        check("R7 ea frozen at reset value", {7'b0, ea_eff}, 8'h00);
        read_at(CTL_VERIFY, 14'h0020);
        check("R7 verify still allowed", dout, 8'hC3);
        setup(CTL_PGM_CODE, 14'h0020, 8'h00);
        @(negedge clk) prog_strobe = 1'b1;
        @(negedge clk) prog_strobe = 1'b0;
        check("R10 reject pulse high", {7'b0, rejected}, 8'h01);
        @(negedge clk);
        check("R10 reject pulse one cycle", {7'b0, rejected}, 8'h00);
        pulses(4);
        read_at(CTL_VERIFY, 14'h0020);
        check("R7 write ignored", dout, 8'hC3);

        // R7 latch across reset
        ea_pin = 1'b1;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) ea_pin = 1'b0;
        @(negedge clk);
        check("R7 ea latched 1", {7'b0, ea_eff}, 8'h01);

        // R8 level 2
        setup(CTL_LOCK2, 14'h0000, 8'h00);
        pulses(25);
        check("R8 level2 permits", perms(), 8'h01);
        setup(CTL_VERIFY, 14'h0020, 8'h00);
        @(negedge clk);
        check("R8 verify blocked", dout, 8'hFF);
        check("R10 verify reject", {7'b0, rejected}, 8'h01);
        @(negedge clk);
        check("R10 verify reject one cycle", {7'b0, rejected}, 8'h00);

        // R9 level 3
        setup(CTL_LOCK3, 14'h0000, 8'h00);
        pulses(25);
        check("R9 level3 permits", perms(), 8'h00);

        do_erase();
        check("R2 final erase permits", perms(), 8'h0F);
        read_at(CTL_VERIFY, 14'h0020);
        check("R2 final erase code", dout, 8'hFF);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule